// File: doc/BRIEF.md
# Unaligned DMA Burst Write Sequencer

This block sequences one bus-master burst on a 32-bit multiplexed address/data bus, moving FIFO bytes into a host buffer (write) or fetching them from memory (read). A start pulse supplies a byte address, the space still owned in the buffer and the bytes left in the current frame. The block drives one address phase with the address rounded down to a DWord and the two low bits forced to zero, then a run of data phases with active-low byte enables. On writes, the first phase covers only the lanes from the start offset up to the DWord boundary. The last phase is trimmed only where the buffer itself ends. A frame that runs out inside owned space still closes with a full DWord.

A configuration bit selects the write wait-state policy: a one-cycle wait before every data phase, or a wait before the first data phase only. Separate enables allow bursting for reads and for writes. When bursting is not allowed, or when a stop request is seen as a phase completes, the burst ends early and reports the next address and the bytes still to move, so the transfer can resume.

The FSM has four states. IDLE goes to ADDR on an accepted start. ADDR goes to WAIT on a write and to DATA on a read. WAIT always goes to DATA. DATA stays put while the target is not ready. On a completed phase, DATA goes back to IDLE when the burst finishes. Otherwise it goes to WAIT (write with wait on every phase) or stays in DATA for the next phase.

Top module: `dma_burst_seq`

## Requirements
- R1: One cycle after an accepted start, `addr_phase` is high for exactly one cycle and `ad` carries the start address with bits [1:0] cleared.
- R2: On a read, every data phase has `cbe_n` = 0000 and `irdy` high with no wait cycle. The phase count is ceil((offset + min(frame, buffer)) / 4).
- R3: On a write, the first data phase enables only byte lanes offset..3. `cbe_n` bit i low means lane i (data bits 8i+7..8i) is written. For example, offset 1 gives `cbe_n` = 0001.
- R4: On a write, every phase between the first and the last has `cbe_n` = 0000. When the buffer ends before the rounded frame end, the last phase enables only the lanes below the buffer end. For example, 9 bytes from offset 0 gives three phases ending with `cbe_n` = 1110.
- R5: When the frame ends inside the owned buffer, the write ends at the frame end rounded up to a DWord boundary, capped by the buffer end. The last phase then has `cbe_n` = 0000.
- R6: With `first_wait_only` = 0, each write data phase is preceded by exactly one cycle in which `busy` is high and `irdy` is low.
- R7: With `first_wait_only` = 1, a write burst has exactly one such wait cycle, placed before the first data phase.
- R8: With the burst enable for the direction low, exactly one data phase runs. Then `rem_addr` is the next DWord address and `rem_bytes` is the number of bytes left to the computed end.
- R9: A data phase completes only on a cycle with `irdy` and `trdy` both high. While `trdy` is low, `ad` and `cbe_n` hold their values.
- R10: After each completed phase that is not the last, `ad` advances by 4.
- R11: `stop_req` high at a phase completion ends the burst after that phase. `rem_addr` and `rem_bytes` then report the resume point. After a full burst, `rem_bytes` is 0 and `rem_addr` is the DWord after the last phase.
- R12: After reset and when idle, `busy`, `irdy`, `addr_phase` and `done` are low and `cbe_n` is 1111. A start with zero buffer or frame bytes is ignored. `done` pulses for one cycle as the state returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted in IDLE |
| wr | input | 1 | 1 = write burst, 0 = read burst |
| start_addr | input | 32 | Byte start address |
| buf_bytes | input | 16 | Bytes of owned buffer space |
| frame_bytes | input | 16 | Bytes left in the frame |
| burst_rd_en | input | 1 | Allow multi-phase reads |
| burst_wr_en | input | 1 | Allow multi-phase writes |
| first_wait_only | input | 1 | Write wait policy: 0 = every phase, 1 = first phase only |
| trdy | input | 1 | Target ready |
| stop_req | input | 1 | End burst at this phase completion |
| busy | output | 1 | Burst in progress |
| addr_phase | output | 1 | Address phase cycle |
| ad | output | 32 | Phase address |
| cbe_n | output | 4 | Active-low byte enables |
| irdy | output | 1 | Master ready |
| done | output | 1 | One-cycle end-of-burst pulse |
| rem_addr | output | 32 | Resume address |
| rem_bytes | output | 16 | Bytes left to the computed end |

## Verification
A wrong latched end or phase index shows at the byte enables of the first or last data phase. It also shows in the phase count before `done`, at the latest one cycle after the final completion. A state register stuck in DATA or WAIT shows as a missing or extra wait cycle within one phase. A counter that advances without a handshake shows as `ad` or `cbe_n` changing during a stalled phase, in the cycle after `trdy` falls.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_WAIT = 2'd2,
        S_DATA = 2'd3
    } seq_state_t;
endpackage

// File: rtl/dbs_plan.sv
// Computes the byte-relative end of the transfer and the index of the final phase.
module dbs_plan #(
    parameter int LW = 16
) (
    input  logic [1:0]    off,
    input  logic [LW-1:0] buf_len,
    input  logic [LW-1:0] frame_len,
    input  logic          wr,
    output logic [LW+1:0] end_o,
    output logic [LW-1:0] last_o
);
    localparam int EW = LW + 2;

    logic [EW-1:0] fr_end, fr_up, bf_end, rd_end, nph;

    always_comb begin
        fr_end = EW'(frame_len) + EW'(off);
        fr_up  = (fr_end + EW'(3)) & ~EW'(3);
        bf_end = EW'(buf_len) + EW'(off);
        rd_end = EW'(off) + ((frame_len < buf_len) ? EW'(frame_len) : EW'(buf_len));
        end_o  = wr ? ((fr_up < bf_end) ? fr_up : bf_end) : rd_end;
        nph    = (end_o + EW'(3)) >> 2;
        last_o = LW'(nph - EW'(1));
    end
endmodule

// File: rtl/dbs_lanes.sv
// Byte-enable generation for one data phase.
module dbs_lanes #(
    parameter int KW = 16
) (
    input  logic [KW-1:0] k,
    input  logic [KW-1:0] last,
    input  logic [1:0]    off,
    input  logic [1:0]    end_lo,
    input  logic          wr,
    output logic [3:0]    cbe_n
);
    logic [2:0] lo, hi;

    always_comb begin
        lo = (k == '0) ? {1'b0, off} : 3'd0;
        hi = (k == last) ? ((end_lo == 2'd0) ? 3'd4 : {1'b0, end_lo}) : 3'd4;
    end

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign cbe_n[i] = wr ? !((3'(i) >= lo) && (3'(i) < hi)) : 1'b0;
    end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dbs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] buf_bytes,
    input  logic [LW-1:0] frame_bytes,
    input  logic          burst_rd_en,
    input  logic          burst_wr_en,
    input  logic          first_wait_only,
    input  logic          trdy,
    input  logic          stop_req,
    output logic          busy,
    output logic          addr_phase,
    output logic [AW-1:0] ad,
    output logic [3:0]    cbe_n,
    output logic          irdy,
    output logic          done,
    output logic [AW-1:0] rem_addr,
    output logic [LW-1:0] rem_bytes
);
    localparam int EW = LW + 2;
    localparam int BW = AW - 2;

    seq_state_t    state_q, state_d;
    logic [BW-1:0] base_q;
    logic [1:0]    off_q;
    logic [EW-1:0] end_q, end_c, consumed;
    logic [LW-1:0] last_q, last_c, k_q;
    logic [AW-1:0] saddr_q, phase_addr;
    logic          wr_q, mode_q, burst_q, done_q;
    logic [3:0]    lane_n;
    logic          accept, finish;

    dbs_plan #(.LW(LW)) plan_i (
        .off      (start_addr[1:0]),
        .buf_len  (buf_bytes),
        .frame_len(frame_bytes),
        .wr       (wr),
        .end_o    (end_c),
        .last_o   (last_c)
    );

    dbs_lanes #(.KW(LW)) lanes_i (
        .k     (k_q),
        .last  (last_q),
        .off   (off_q),
        .end_lo(end_q[1:0]),
        .wr    (wr_q),
        .cbe_n (lane_n)
    );

    assign accept     = (state_q == S_IDLE) && start && (buf_bytes != '0) && (frame_bytes != '0);
    assign finish     = (k_q == last_q) || stop_req || !burst_q;
    assign phase_addr = {base_q + BW'(k_q), 2'b00};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_ADDR;
            S_ADDR: state_d = wr_q ? S_WAIT : S_DATA;
            S_WAIT: state_d = S_DATA;
            S_DATA: if (trdy) begin
                if (finish)                 state_d = S_IDLE;
                else if (wr_q && !mode_q)   state_d = S_WAIT;
                else                        state_d = S_DATA;
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            off_q   <= '0;
            end_q   <= '0;
            last_q  <= '0;
            k_q     <= '0;
            saddr_q <= '0;
            wr_q    <= 1'b0;
            mode_q  <= 1'b0;
            burst_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == S_DATA) && trdy && finish;
            if (accept) begin
                base_q  <= start_addr[AW-1:2];
                off_q   <= start_addr[1:0];
                end_q   <= end_c;
                last_q  <= last_c;
                k_q     <= '0;
                saddr_q <= start_addr;
                wr_q    <= wr;
                mode_q  <= first_wait_only;
                burst_q <= wr ? burst_wr_en : burst_rd_en;
            end else if ((state_q == S_DATA) && trdy) begin
                k_q <= k_q + LW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = 1'b0;
        addr_phase = 1'b0;
        irdy       = 1'b0;
        ad         = '0;
        cbe_n      = 4'hF;
        unique case (state_q)
            S_IDLE: ;
            S_ADDR: begin
                busy       = 1'b1;
                addr_phase = 1'b1;
                ad         = {base_q, 2'b00};
            end
            S_WAIT: begin
                busy  = 1'b1;
                ad    = phase_addr;
                cbe_n = lane_n;
            end
            S_DATA: begin
                busy  = 1'b1;
                irdy  = 1'b1;
                ad    = phase_addr;
                cbe_n = lane_n;
            end
        endcase
    end

    assign done      = done_q;
    assign consumed  = (k_q == '0) ? EW'(off_q) : {k_q, 2'b00};
    assign rem_addr  = (k_q == '0) ? saddr_q : phase_addr;
    assign rem_bytes = (end_q > consumed) ? LW'(end_q - consumed) : '0;
endmodule

// File: rtl/dbs_chk.sv
module dbs_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          addr_phase,
    input logic          irdy,
    input logic          trdy,
    input logic          done,
    input logic          wr_q,
    input logic [AW-1:0] ad,
    input logic [3:0]    cbe_n
);
    // R1
    addr_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> ad[1:0] == 2'b00);

    // R2
    rd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !addr_phase && !wr_q) |-> (cbe_n == 4'h0 && irdy));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && irdy && !trdy) |=> ($stable(cbe_n) && $stable(ad)));

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && irdy && trdy) |=> (!busy || ad == $past(ad) + AW'(4)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!irdy && !addr_phase && cbe_n == 4'hF));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dma_burst_seq dbs_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .addr_phase(addr_phase),
    .irdy      (irdy),
    .trdy      (trdy),
    .done      (done),
    .wr_q      (wr_q),
    .ad        (ad),
    .cbe_n     (cbe_n)
);

// File: tb/dma_burst_seq_tb_top.sv
module dma_burst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, wr = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] buf_bytes = '0, frame_bytes = '0;
    logic        burst_rd_en = 1'b1, burst_wr_en = 1'b1, first_wait_only = 1'b0;
    logic        trdy = 1'b1, stop_req = 1'b0;
    logic        busy, addr_phase, irdy, done;
    logic [31:0] ad, rem_addr;
    logic [3:0]  cbe_n;
    logic [15:0] rem_bytes;

    int checks = 0, errors = 0, cyc = 0;
    int r_ph, r_wait;
    logic [3:0]  r_first, r_last;
    logic [31:0] r_ad;

    always #4 clk = ~clk;

    dma_burst_seq dut_i (.*);

    localparam int NV = 8;
    localparam logic [31:0] V_ADDR [NV] = '{32'h1001, 32'h2000, 32'h3000, 32'h4002,
                                            32'h5003, 32'h6001, 32'h7002, 32'h8001};
    localparam logic [15:0] V_BUF  [NV] = '{16'd100, 16'd9, 16'd20, 16'd10, 16'd1, 16'd40, 16'd6, 16'd2};
    localparam logic [15:0] V_FRM  [NV] = '{16'd100, 16'd50, 16'd5, 16'd1, 16'd1, 16'd10, 16'd30, 16'd30};
    localparam logic        V_WR   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic        V_MODE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int          V_NPH  [NV] = '{26, 3, 2, 1, 1, 3, 2, 1};
    localparam logic [3:0]  V_FST  [NV] = '{4'b0001, 4'b0000, 4'b0000, 4'b0011,
                                            4'b0111, 4'b0000, 4'b0011, 4'b1001};
    localparam logic [3:0]  V_LST  [NV] = '{4'b1110, 4'b1110, 4'b0000, 4'b0011,
                                            4'b0111, 4'b0000, 4'b0000, 4'b1001};
    localparam int          V_WT   [NV] = '{26, 1, 2, 1, 1, 0, 1, 1};
    localparam logic [31:0] V_REM  [NV] = '{32'h1068, 32'h200C, 32'h3008, 32'h4004,
                                            32'h5004, 32'h600C, 32'h7008, 32'h8004};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [15:0] b, input logic [15:0] f,
                       input logic w, input logic m, input logic bwe, input logic stp,
                       input logic gap);
        int stallc = 0;
        r_ph = 0; r_wait = 0; r_first = 4'hx; r_last = 4'hx; r_ad = 'x;
        @(negedge clk);
        start_addr = a; buf_bytes = b; frame_bytes = f; wr = w;
        first_wait_only = m; burst_wr_en = bwe; stop_req = stp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int it = 0; it < 2000 && !done; it++) begin
            if (gap && r_ph == 2 && irdy && stallc < 3) begin
                trdy = 1'b0; stallc++;
            end else trdy = 1'b1;
            if (addr_phase) r_ad = ad;
            else if (busy && !irdy) r_wait++;
            else if (busy && irdy && trdy) begin
                if (r_ph == 0) r_first = cbe_n;
                r_last = cbe_n;
                r_ph++;
            end
            @(negedge clk);
        end
        trdy = 1'b1; stop_req = 1'b0; burst_wr_en = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy at reset", 32'(busy), 0);
        chk("R12 cbe_n at reset", 32'(cbe_n), 32'hF);
        chk("R12 irdy/done at reset", 32'({irdy, done, addr_phase}), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run(V_ADDR[v], V_BUF[v], V_FRM[v], V_WR[v], V_MODE[v], 1'b1, 1'b0, 1'b0);
            chk("R1 address phase aligned", r_ad, V_ADDR[v] & ~32'h3);
            chk("R2/R5 phase count", 32'(r_ph), 32'(V_NPH[v]));
            chk("R3 first phase lanes", 32'(r_first), 32'(V_FST[v]));
            chk("R4/R5 last phase lanes", 32'(r_last), 32'(V_LST[v]));
            chk("R6/R7 wait cycles", 32'(r_wait), 32'(V_WT[v]));
            chk("R11 rem_addr after burst", rem_addr, V_REM[v]);
            chk("R11 rem_bytes after burst", 32'(rem_bytes), 0);
        end

        // R8 burst disabled: single phase, resume point reported
        run(32'h9001, 16'd100, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 single phase", 32'(r_ph), 1);
        chk("R8 lanes", 32'(r_first), 32'b0001);
        chk("R8 rem_addr", rem_addr, 32'h9004);
        chk("R8 rem_bytes", 32'(rem_bytes), 97);

        // R11 stop request ends after the first completed phase
        run(32'hA000, 16'd64, 16'd64, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R11 stop phases", 32'(r_ph), 1);
        chk("R11 stop rem_addr", rem_addr, 32'hA004);
        chk("R11 stop rem_bytes", 32'(rem_bytes), 60);

        // R9 target stalls mid-burst; phase count and lanes unchanged
        run(32'hB002, 16'd30, 16'd30, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R9 phases with stall", 32'(r_ph), 8);
        chk("R9 last lanes with stall", 32'(r_last), 32'b0000);
        chk("R10 rem_addr with stall", rem_addr, 32'hB020);

        // R12 zero-length start ignored
        @(negedge clk);
        buf_bytes = 16'd0; frame_bytes = 16'd8; wr = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 zero-length ignored busy", 32'(busy), 0);
        @(negedge clk);
        chk("R12 zero-length no done", 32'(done), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule